// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

The block collects 32 interrupt request lines and merges them into one interrupt for the processor. Lines 0 to 19 carry the four request pins (A to D) of five expansion slots, bit 31 carries a cascaded request from a legacy bus controller, and bits 20 to 30 are unconnected. Every line has its own enable bit, trigger-mode bit and active-level bit. An edge-mode line latches a request on its active transition. Software drops that latch by writing a one to the line's bit in a clear register and then writing zero. A level-mode line simply follows its input.

Software reads a summary word of the pending requests, filtered by a board-level valid-bits parameter, so reserved lines never appear. The processor interrupt is the OR of the enabled summary bits, registered. A separate write-only register accepts one key value and answers it with a one-cycle system restart request. Raw inputs cross into the clock domain through a two-flop synchroniser.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable, trigger-mode and clear registers read 0, the polarity register reads 0x80000000, and `cpu_irq` and `rst_req` are low.
- R2: Register offsets on `addr`: 0 enable (1 = line enabled), 1 trigger mode (1 = edge, 0 = level), 2 polarity (1 = active high, 0 = active low), 3 clear, 4 summary (read only), 5 restart key (write only, reads 0). A written value reads back unchanged at offsets 0 to 3.
- R3: A level-mode line shows pending in the summary while its synchronised input is at its active level, and not otherwise.
- R4: An edge-mode line latches on an inactive-to-active transition and stays pending after the input returns inactive.
- R5: While a line's clear bit is 1 its edge latch is dropped, and it stays dropped after the clear register is written back to 0 until a new active transition. In level mode the clear register has no lasting effect on the summary.
- R6: Summary bits 20 to 30 always read 0, whatever the inputs and polarity.
- R7: `cpu_irq` is high one cycle after the summary ANDed with the enable register is non-zero, and low when no enabled valid line is pending.
- R8: Line 31 (the cascade) is active high after reset, while lines 0 to 30 are active low.
- R9: A write of 0x0000DEAD to offset 5 gives a `rst_req` pulse exactly one cycle long; any other value written there leaves `rst_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| cpu_irq | output | 1 | Combined interrupt to the processor |
| rst_req | output | 1 | One-cycle system restart request |

## Verification
The bench goes after the clear handshake: a design that cleared on the write of zero, or let the latch re-arm from a still-active input, would show the edge line pending again after the clear sequence. It checks level lines under a clear write, where a design that latched them would hide a live request. All inputs are driven active, so a design that leaked reserved bits would report bits 20 to 30 and raise `cpu_irq` with only reserved lines enabled. Near-miss restart keys are written, which a loose comparator would turn into a restart.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int          NL        = 32,
  parameter logic [31:0] VALID     = 32'h800F_FFFF,
  parameter logic [31:0] POL_INIT  = 32'h8000_0000,
  parameter logic [31:0] RST_KEY   = 32'h0000_DEAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [NL-1:0] wdata,
  output logic [NL-1:0] rdata,
  output logic          cpu_irq,
  output logic          rst_req
);
  localparam logic [2:0] A_EN = 3'd0, A_MODE = 3'd1, A_POL = 3'd2,
                         A_CLR = 3'd3, A_SUM = 3'd4, A_KEY = 3'd5;
  localparam logic [NL-1:0] VMASK = VALID[NL-1:0];

  logic [NL-1:0] en_q, mode_q, pol_q, clr_q;
  logic [NL-1:0] s1, s2, act_q, lat_q;
  logic [NL-1:0] act, pend, summary;

  assign act     = ~(s2 ^ pol_q);
  assign pend    = (mode_q & lat_q) | (~mode_q & act);
  assign summary = pend & VMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= POL_INIT[NL-1:0];
      clr_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_EN:    en_q   <= wdata;
        A_MODE:  mode_q <= wdata;
        A_POL:   pol_q  <= wdata;
        A_CLR:   clr_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      act_q   <= '0;
      lat_q   <= '0;
      cpu_irq <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      s1      <= irq_in;
      s2      <= s1;
      act_q   <= act;
      lat_q   <= (lat_q | (mode_q & act & ~act_q)) & ~clr_q;
      cpu_irq <= |(summary & en_q);
      rst_req <= wr_en && (addr == A_KEY) && (wdata == RST_KEY[NL-1:0]);
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = en_q;
      A_MODE:  rdata = mode_q;
      A_POL:   rdata = pol_q;
      A_CLR:   rdata = clr_q;
      A_SUM:   rdata = summary;
      default: rdata = '0;
    endcase
  end

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(lat_q) & ~$past(clr_q)) & ~lat_q) == '0));

  // R5
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_q) & lat_q) == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en_q) & VMASK) == '0) |-> !cpu_irq);

  // R9
  key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wr_en) && $past(addr) == A_KEY));

  // R9
  key_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !wr_en) |=> !rst_req);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu_irq, rst_req;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq), .rst_req(rst_req));

  // {polarity, input, expected summary}
  localparam logic [95:0] VEC [0:5] = '{
    {32'h8000_0000, 32'h0000_0000, 32'h000F_FFFF},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},
    {32'hFFFF_FFFF, 32'h0000_00A5, 32'h0000_00A5},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h800F_FFFF},
    {32'h0000_0000, 32'h000F_0F0F, 32'h8000_F0F0},
    {32'h0000_FFFF, 32'h1234_5678, 32'h800B_5678}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    // R1 reset state
    chk({31'd0, cpu_irq}, 32'd0, "R1 cpu_irq");
    chk({31'd0, rst_req}, 32'd0, "R1 rst_req");
    rst_n = 1'b1;
    rd(3'd0, v); chk(v, 32'h0, "R1 enable");
    rd(3'd1, v); chk(v, 32'h0, "R1 mode");
    rd(3'd2, v); chk(v, 32'h8000_0000, "R1 polarity");
    rd(3'd3, v); chk(v, 32'h0, "R1 clear");
    // R2 readback
    wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, v); chk(v, 32'hA5A5_0F0F, "R2 enable");
    wr(3'd1, 32'h1234_8765); rd(3'd1, v); chk(v, 32'h1234_8765, "R2 mode");
    rd(3'd5, v); chk(v, 32'h0, "R2 key reads 0");
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    // R3 R6 R8 level vectors
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, VEC[i][95:64]);
      irq_in = VEC[i][63:32];
      wait_cyc(4);
      rd(3'd4, v);
      chk(v, VEC[i][31:0], $sformatf("R3 R6 R8 vector %0d", i));
    end
    // R6 reserved only enabled: no interrupt
    wr(3'd2, 32'hFFFF_FFFF); irq_in = 32'hFFFF_FFFF;
    wr(3'd0, 32'h7FF0_0000); wait_cyc(4);
    chk({31'd0, cpu_irq}, 32'd0, "R6 reserved cpu_irq");
    // R4 edge latch on line 3
    irq_in = 32'h0; wr(3'd0, 32'h0); wr(3'd1, 32'h0000_0008); wait_cyc(4);
    rd(3'd4, v); chk(v & 32'h8, 32'h0, "R4 idle");
    irq_in = 32'h0000_0008; wait_cyc(4);
    rd(3'd4, v); chk(v & 32'h8, 32'h8, "R4 latched");
    irq_in = 32'h0; wait_cyc(4);
    rd(3'd4, v); chk(v & 32'h8, 32'h8, "R4 held");
    // R7
    chk({31'd0, cpu_irq}, 32'd0, "R7 masked off");
    wr(3'd0, 32'h0000_0008); wait_cyc(2);
    chk({31'd0, cpu_irq}, 32'd1, "R7 enabled");
    // R5 clear handshake
    wr(3'd3, 32'h0000_0008); rd(3'd4, v); chk(v & 32'h8, 32'h0, "R5 cleared");
    wr(3'd3, 32'h0); wait_cyc(3);
    rd(3'd4, v); chk(v & 32'h8, 32'h0, "R5 stays cleared");
    chk({31'd0, cpu_irq}, 32'd0, "R7 drops after clear");
    // R5 level line 4 not affected by clear
    irq_in = 32'h0000_0010; wait_cyc(4);
    wr(3'd3, 32'h0000_0010); wr(3'd3, 32'h0); wait_cyc(2);
    rd(3'd4, v); chk(v & 32'h10, 32'h10, "R5 level unaffected");
    // R9 restart key
    @(negedge clk); wr_en = 1'b1; addr = 3'd5; wdata = 32'h0000_DEAD;
    @(negedge clk); wr_en = 1'b0;
    chk({31'd0, rst_req}, 32'd1, "R9 pulse");
    @(negedge clk);
    chk({31'd0, rst_req}, 32'd0, "R9 one cycle");
    @(negedge clk); wr_en = 1'b1; addr = 3'd5; wdata = 32'h0000_DEAE;
    @(negedge clk); wr_en = 1'b0;
    chk({31'd0, rst_req}, 32'd0, "R9 wrong key");
    @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 32'h0000_DEAD;
    @(negedge clk); wr_en = 1'b0;
    chk({31'd0, rst_req}, 32'd0, "R9 wrong offset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule